// File: doc/BRIEF.md
# Reconfigurable Pulse-Width Print Head Driver

This block drives 64 print elements, each with an on-pulse whose length follows that element's 8-bit gray level (256 levels). One 64×8 array of storage cells does two jobs. While pixel data is loaded, the cells form eight parallel shift chains, one per serial data line. Once printing starts, the links between cells change, and each channel's eight bits become a down-counter that times its own output. No separate latch or comparator is kept per channel.

In use, the host holds the mode input low and presents one pixel per clock on the eight serial lines, with bit k of every pixel on line k. After 64 clocks each channel holds its value. The host then raises the mode input and pulses the start strobe. Every nonzero channel drives its output high. Each counter steps down once per count tick, which is one tick every `TICK_DIV` clocks. A channel's output drops when its counter reaches zero. The done flag rises once every channel has finished, and it stays up until the mode input returns low.

Top module: `pwm_head_drv`

## Requirements
- R1: After reset every output enable is low, done is low and every channel holds zero.
- R2: While mode_count is 0 and no pulse run is active, every clock shifts all chains by one: line k enters bit k of channel 63 and bit k of channel i+1 moves to channel i. The pixel presented on the j-th of 64 consecutive shift clocks (j counted from 0) ends in channel j.
- R3: A start strobe seen with mode_count = 1 while no run is active begins a run. In the first cycle after that clock edge, every channel holding a nonzero value has its output enable high.
- R4: A channel loaded with value v (1 to 255) keeps its output enable high for exactly v × TICK_DIV consecutive clocks and never raises it again during the same run.
- R5: A channel loaded with zero gives no pulse, and no output enable is high outside a run.
- R6: Done rises max(v) × TICK_DIV + 1 clocks after the start edge, or 1 clock after it when all channels are zero. It stays high, with every output low, until mode_count returns to 0.
- R7: During a run, changes on the serial lines, mode_count returning to 0 and further start strobes have no effect on the pulse widths or on done.
- R8: A run leaves every channel at zero, so a second start without a reload produces no pulse and raises done one clock after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for shifting and counting |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_count | input | 1 | 0 = load by shifting, 1 = pulse (count) mode |
| start | input | 1 | Strobe that begins a pulse run in count mode |
| sdi | input | 8 | Serial data lines, line k carries bit k of each pixel |
| drive_en | output | 64 | Per-element output enable |
| done | output | 1 | All channels have finished their pulses |

## Verification
After the start edge, outputs are due in the first cycle and stay high for v × TICK_DIV cycles. Done is due max(v) × TICK_DIV + 1 cycles after the edge. The bench numbers every sample taken after the start edge, beginning at 0. For each channel it counts the samples in which that channel is high, checks that sample 0 is high exactly when the value is nonzero, and records the index of the first sample with done high. Loading is checked through the pulse widths. All zero patterns, full-scale patterns, disturbances during a run and a restart without a reload are swept with a divider of 2.

// File: rtl/pwm_head_pkg.sv
package pwm_head_pkg;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RUN = 2'd1, ST_FIN = 2'd2} run_state_t;

  // Next value of one storage cell: shift load wins, else step down on a tick.
  function automatic logic [7:0] cell_next(input logic [7:0] cur,
                                           input logic [7:0] sin,
                                           input logic       do_shift,
                                           input logic       do_tick);
    if (do_shift)                   return sin;
    else if (do_tick && cur != '0)  return cur - 8'd1;
    else                            return cur;
  endfunction
endpackage

// File: rtl/hd_cell.sv
module hd_cell #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_go,
  input  logic            tick_go,
  input  logic [BITS-1:0] sin,
  output logic [BITS-1:0] val,
  output logic            nz
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      val <= '0;
    else if (shift_go)               val <= sin;
    else if (tick_go && val != '0)   val <= val - 1'b1;
  end
  assign nz = (val != '0);
endmodule

// File: rtl/hd_prescale.sv
module hd_prescale #(
  parameter int TICK_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic tick
);
  generate
    if (TICK_DIV <= 1) begin : g_every
      assign tick = run;
    end else begin : g_div
      localparam int CW = $clog2(TICK_DIV);
      localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (clear)       cnt <= '0;
        else if (run)         cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end
      assign tick = run && (cnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/hd_ctrl.sv
module hd_ctrl
  import pwm_head_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mode_count,
  input  logic start,
  input  logic any_nz,
  output logic busy,
  output logic done,
  output logic shift_go,
  output logic run_go
);
  run_state_t st, st_n;

  assign busy     = (st == ST_RUN);
  assign done     = (st == ST_FIN);
  assign shift_go = !busy && !mode_count;
  assign run_go   = !busy && mode_count && start;

  always_comb begin
    st_n = st;
    unique case (st)
      ST_IDLE: if (run_go) st_n = ST_RUN;
      ST_RUN:  if (!any_nz) st_n = ST_FIN;
      ST_FIN:  if (run_go) st_n = ST_RUN;
               else if (!mode_count) st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_n;
  end
endmodule

// File: rtl/pwm_head_drv.sv
module pwm_head_drv #(
  parameter int NCH      = 64,
  parameter int BITS     = 8,
  parameter int TICK_DIV = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_count,
  input  logic            start,
  input  logic [BITS-1:0] sdi,
  output logic [NCH-1:0]  drive_en,
  output logic            done
);
  localparam int LAST_CH = NCH - 1;

  logic [BITS-1:0] cell_q [NCH];
  logic [NCH-1:0]  cell_nz;
  logic            busy, shift_go, run_go, tick, any_nz;

  hd_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_count(mode_count), .start(start),
    .any_nz(any_nz), .busy(busy), .done(done), .shift_go(shift_go), .run_go(run_go)
  );

  hd_prescale #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .clear(run_go), .run(busy), .tick(tick)
  );

  genvar i;
  generate
    for (i = 0; i < NCH; i++) begin : g_ch
      logic [BITS-1:0] sin;
      if (i == LAST_CH) begin : g_head
        assign sin = sdi;
      end else begin : g_link
        assign sin = cell_q[i+1];
      end
      hd_cell #(.BITS(BITS)) u_cell (
        .clk(clk), .rst_n(rst_n), .shift_go(shift_go), .tick_go(tick),
        .sin(sin), .val(cell_q[i]), .nz(cell_nz[i])
      );
    end
  endgenerate

  assign any_nz   = |cell_nz;
  assign drive_en = busy ? cell_nz : '0;
endmodule

// File: rtl/pwm_head_chk.sv
module pwm_head_chk #(
  parameter int NCH = 64
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mode_count,
  input logic           start,
  input logic [NCH-1:0] drive_en,
  input logic           done,
  input logic           busy,
  input logic           tick
);
  a_r3_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode_count && !busy) |=> busy);

  a_r4_no_rise_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || ((drive_en & ~$past(drive_en)) == '0)));

  a_r4_tick_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> busy);

  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (drive_en == '0));

  a_r6_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && drive_en == '0) |=> done);

  a_r6_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && drive_en == '0));

  a_r7_run_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && drive_en != '0) |=> busy);
endmodule

bind pwm_head_drv pwm_head_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_count(mode_count), .start(start),
  .drive_en(drive_en), .done(done), .busy(busy), .tick(tick)
);

// File: tb/tb_pwm_head_drv.sv
module tb_pwm_head_drv;
  localparam int NCH = 64;
  localparam int BITS = 8;
  localparam int DIV = 2;
  localparam int MAXS = 255 * DIV + 8;

  logic clk = 0, rst_n = 0, mode_count = 0, start = 0;
  logic [BITS-1:0] sdi = '0;
  logic [NCH-1:0] drive_en;
  logic done;
  int errors = 0, checks = 0;
  int pix [NCH];

  always #4 clk = ~clk;

  pwm_head_drv #(.NCH(NCH), .BITS(BITS), .TICK_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .mode_count(mode_count), .start(start),
    .sdi(sdi), .drive_en(drive_en), .done(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R2: pixel j presented on shift clock j lands in channel j
  task automatic load();
    mode_count = 0; start = 0;
    for (int j = 0; j < NCH; j++) begin
      sdi = pix[j][BITS-1:0];
      @(negedge clk);
    end
    mode_count = 1;
    @(negedge clk);
  endtask

  task automatic run(input string tag, input bit disturb);
    int hi [NCH];
    bit first [NCH];
    int done_at = -1, mx = 0;
    for (int c = 0; c < NCH; c++) begin
      hi[c] = 0; first[c] = 0;
      if (pix[c] > mx) mx = pix[c];
    end
    start = 1;
    @(negedge clk);
    start = 0;
    for (int s = 0; s < MAXS; s++) begin
      for (int c = 0; c < NCH; c++) begin
        if (drive_en[c]) hi[c]++;
        if (s == 0) first[c] = drive_en[c];
      end
      if (done && done_at < 0) done_at = s;
      if (disturb && s > 2 && done_at < 0) begin
        mode_count = s[0]; sdi = BITS'(s * 7); start = s[1];   // R7
      end else begin
        mode_count = 1; start = 0;
      end
      @(negedge clk);
    end
    for (int c = 0; c < NCH; c++) begin
      chk({tag, " R4 width"}, hi[c], pix[c] * DIV);
      chk({tag, " R3/R5 first"}, int'(first[c]), (pix[c] != 0) ? 1 : 0);
    end
    chk({tag, " R6 done time"}, done_at, (mx == 0) ? 1 : mx * DIV + 1);
    chk({tag, " R6 held"}, int'(done), 1);
    chk({tag, " R6 outs low"}, int'(drive_en != '0), 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 outs", int'(drive_en), 0);
    chk("R1 done", int'(done), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 outs after release", int'(drive_en != '0), 0);
    // R1: fresh cells are zero -> start gives no pulse, done at sample 1
    for (int j = 0; j < NCH; j++) pix[j] = 0;
    mode_count = 1; @(negedge clk);
    run("R1 reset zero", 0);

    for (int j = 0; j < NCH; j++) pix[j] = (j * 4) % 256;
    load(); run("ramp", 0);

    for (int j = 0; j < NCH; j++) pix[j] = 255 - j * 3;
    load(); run("fullscale", 0);

    for (int j = 0; j < NCH; j++) pix[j] = (j * 37 + 11) % 256;
    load(); run("R7 disturbed", 1);

    // R8: no reload, cells emptied by the run
    for (int j = 0; j < NCH; j++) pix[j] = 0;
    mode_count = 1; @(negedge clk);
    run("R8 rerun", 0);

    for (int j = 0; j < NCH; j++) pix[j] = (j == 0 || j == 63) ? 255 : ((j == 31) ? 1 : 0);
    load(); run("R2 ends", 0);

    // R6: done drops when mode returns to shift
    mode_count = 0; @(negedge clk);
    chk("R6 done clears", int'(done), 0);
    chk("R5 idle outs", int'(drive_en != '0), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule